// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Channel

This block is one receive DMA channel. It takes a byte stream of packets and stores them in memory buffers. The buffers are described by a linked list of four-word descriptors that live in the same memory. Software builds the list and credits the channel with a number of free buffers. It then writes the address of the first descriptor into the head-pointer register.

The engine fetches each descriptor over a single-cycle synchronous SRAM port. It packs incoming bytes into 32-bit words inside that descriptor's buffer. When the buffer is done, it writes back a status word in one memory write. That word carries packet framing flags, the byte count, the cleared ownership flag and, at the tail of the list, an end-of-queue flag.

Software acknowledges each finished descriptor by writing its address to the completion-pointer register. The interrupt stays up until that acknowledgement catches up with the engine. An idle request parks the engine at the next packet boundary. A self-clearing soft reset aborts everything in flight.

Descriptor layout, at byte offsets from the descriptor address:

| Offset | Contents |
|---|---|
| +0 | next descriptor address (0 ends the list) |
| +4 | buffer address (word aligned) |
| +8 | buffer length in bytes, bits [10:0], non-zero |
| +12 | status word written by the engine |

Register word index on `reg_addr`:

| Index | Register |
|---|---|
| 0 | enable |
| 1 | DMA control |
| 2 | status |
| 3 | soft reset |
| 4 | head pointer |
| 5 | completion pointer |
| 6 | free-buffer credit |

Top module: `desc_rx_dma`

## Requirements
- R1: After reset, every register reads 0 except status, which reads 0x80000000. `irq` is 0 and `s_ready` is 0. A register read returns the value on the cycle after `reg_addr` is presented.
- R2: The engine starts under three conditions together: the head pointer is non-zero, enable bit 0 is set, and the free credit is non-zero. It then reads the next pointer, buffer address and length and raises `s_ready`. Byte k of a descriptor's buffer lands in word k/4, bits 8*(k%4)+7 down to 8*(k%4). A word's unused upper bytes read 0.
- R3: Each finished descriptor gets exactly one status write at +12. The status word packs the following fields:
  - bit 31 is set when the descriptor holds the first byte of a packet;
  - bit 30 is set when it holds the last byte;
  - bit 29 (ownership) is 0;
  - bits [10:0] hold the number of bytes stored;
  - all other bits, except bit 28, are 0.
- R4: A descriptor closes when its buffer is full. If that happens before the packet ends, the packet continues in the descriptor named by the next pointer. Only the first descriptor has bit 31 set, and only the last has bit 30 set.
- R5: A descriptor whose next pointer is 0 gets bit 28 (end of queue) in its status word. The head pointer then reads 0, the engine stops and `s_ready` stays 0. A new head-pointer write restarts it.
- R6: A head-pointer write while the head pointer is non-zero is ignored.
- R7: After each descriptor completes, the head pointer reads that descriptor's next pointer. `irq` is 1 while the completion-pointer register differs from the address of the last completed descriptor. Writing that address clears `irq` within two cycles.
- R8: A write to the free-credit register adds `reg_wdata[15:0]`, and each completed descriptor subtracts one. With zero credit no descriptor is started.
- R9: With enable bit 0 clear, no new packet starts.
- R10: Setting DMA control bit 3 lets a packet in progress run to its end, across descriptors, and then starts no new packet. Status bit 31 reads 1 exactly when no packet is in progress and no descriptor is being worked on. Clearing bit 3 resumes reception.
- R11: Writing 1 to soft-reset bit 0 aborts any packet in progress. It clears the head pointer, completion pointer, last completed address, free credit and `irq`, and the next packet starts fresh with bit 31 set. The bit reads 1 while the reset runs and clears itself after RST_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register word index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | registered read data for `reg_addr` |
| irq | output | 1 | completion interrupt |
| mem_addr | output | MEM_AW | SRAM word address |
| mem_we | output | 1 | SRAM write enable |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after the address |
| s_valid | input | 1 | stream byte valid |
| s_data | input | 8 | stream byte |
| s_last | input | 1 | marks the final byte of a packet |
| s_ready | output | 1 | engine accepts the byte this cycle |

## Verification
The hardest situations to reach from the ports arrive in the middle of a packet. Examples are an idle request or a soft reset landing between two bytes, and a packet crossing a descriptor boundary while the follow-on descriptor is still being fetched. The stimulus pushes bytes one at a time, so it can pause the stream at a chosen byte, issue register writes and read back status and the head pointer before resuming. A seeded random run then chains a dozen descriptors with random buffer sizes and feeds random-length packets until the list is exhausted. The bench predicts where every packet splits and what every status word contains.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 11;
  localparam int RA_W   = 3;

  localparam int ST_SOP = 31;
  localparam int ST_EOP = 30;
  localparam int ST_OWN = 29;
  localparam int ST_EOQ = 28;

  localparam int IDLE_REQ_BIT = 3;
  localparam int IDLE_FLAG_BIT = 31;

  localparam logic [RA_W-1:0] RA_ENABLE = 3'd0;
  localparam logic [RA_W-1:0] RA_DMACTL = 3'd1;
  localparam logic [RA_W-1:0] RA_STATUS = 3'd2;
  localparam logic [RA_W-1:0] RA_SRST   = 3'd3;
  localparam logic [RA_W-1:0] RA_HEAD   = 3'd4;
  localparam logic [RA_W-1:0] RA_COMPL  = 3'd5;
  localparam logic [RA_W-1:0] RA_CREDIT = 3'd6;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_FETCH,
    ENG_DATA,
    ENG_WB
  } eng_state_e;
endpackage

// File: rtl/dq_regs.sv
module dq_regs
  import dq_pkg::*;
#(
  parameter int FREE_W     = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              done,
  input  logic [DATA_W-1:0] done_addr,
  input  logic [DATA_W-1:0] done_next,
  input  logic              eng_idle,
  output logic              enable,
  output logic              idle_req,
  output logic [DATA_W-1:0] head,
  output logic              credit_nz,
  output logic              swrst
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic              en_q, req_q, irq_q;
  logic [DATA_W-1:0] head_q, compl_q, last_q, rdata_q;
  logic [FREE_W-1:0] credit_q;
  logic [CW-1:0]     rcnt_q;
  logic              busy;
  logic [FREE_W-1:0] credit_add;

  assign busy       = rcnt_q != '0;
  assign credit_add = (reg_we && reg_addr == RA_CREDIT) ? reg_wdata[FREE_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      req_q    <= 1'b0;
      head_q   <= '0;
      compl_q  <= '0;
      last_q   <= '0;
      credit_q <= '0;
      rcnt_q   <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (reg_we && reg_addr == RA_ENABLE) en_q  <= reg_wdata[0];
      if (reg_we && reg_addr == RA_DMACTL) req_q <= reg_wdata[IDLE_REQ_BIT];
      if (busy) begin
        rcnt_q   <= rcnt_q - 1'b1;
        head_q   <= '0;
        compl_q  <= '0;
        last_q   <= '0;
        credit_q <= '0;
      end else if (reg_we && reg_addr == RA_SRST && reg_wdata[0]) begin
        rcnt_q   <= CW'(RST_CYCLES);
        head_q   <= '0;
        compl_q  <= '0;
        last_q   <= '0;
        credit_q <= '0;
      end else begin
        if (done) head_q <= done_next;
        else if (reg_we && reg_addr == RA_HEAD && head_q == '0) head_q <= reg_wdata;
        if (done) last_q <= done_addr;
        if (reg_we && reg_addr == RA_COMPL) compl_q <= reg_wdata;
        credit_q <= credit_q + credit_add - FREE_W'(done);
      end
      irq_q <= !busy && (compl_q != last_q);
      case (reg_addr)
        RA_ENABLE: rdata_q <= {31'b0, en_q};
        RA_DMACTL: rdata_q <= DATA_W'(req_q) << IDLE_REQ_BIT;
        RA_STATUS: rdata_q <= DATA_W'(eng_idle) << IDLE_FLAG_BIT;
        RA_SRST:   rdata_q <= {31'b0, busy};
        RA_HEAD:   rdata_q <= head_q;
        RA_COMPL:  rdata_q <= compl_q;
        RA_CREDIT: rdata_q <= DATA_W'(credit_q);
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
  assign enable    = en_q;
  assign idle_req  = req_q;
  assign head      = head_q;
  assign credit_nz = credit_q != '0;
  assign swrst     = busy;

  assert_done_live_head_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> head_q != '0);
  assert_credit_available_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> credit_q != '0);
  assert_head_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RA_HEAD && head_q != '0 && !done && !busy)
    |=> head_q == $past(head_q));
  assert_srst_clears_R11: assert property (@(posedge clk) disable iff (rst)
    busy |=> (head_q == '0 && credit_q == '0 && !irq_q));
endmodule

// File: rtl/dq_engine.sv
module dq_engine
  import dq_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swrst,
  input  logic              enable,
  input  logic              idle_req,
  input  logic [DATA_W-1:0] head,
  input  logic              credit_nz,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              done,
  output logic [DATA_W-1:0] done_addr,
  output logic [DATA_W-1:0] done_next,
  output logic              eng_idle
);
  localparam int FETCH_LAST = 4;

  eng_state_e        st_q;
  logic [2:0]        fcnt_q;
  logic [DATA_W-1:0] desc_q, nxt_q, acc_q;
  logic [MEM_AW-1:0] buf_q, desc_w;
  logic [LEN_W-1:0]  blen_q, boff_q, boff_n;
  logic              sop_q, eop_q, inpkt_q;
  logic [MEM_AW-1:0] addr_q;
  logic              we_q, done_q;
  logic [DATA_W-1:0] wdata_q, dnext_q;
  logic              start, take, close_d;
  logic [1:0]        lane;
  logic [DATA_W-1:0] acc_n;

  assign desc_w  = desc_q[MEM_AW+1:2];
  assign start   = st_q == ENG_IDLE && !done_q && head != '0 && credit_nz &&
                   (inpkt_q || (enable && !idle_req));
  assign s_ready = st_q == ENG_DATA && !swrst;
  assign take    = s_ready && s_valid;
  assign lane    = boff_q[1:0];
  assign boff_n  = boff_q + 1'b1;
  assign close_d = s_last || boff_n == blen_q;
  assign acc_n   = (lane == 2'd0) ? {24'b0, s_data}
                                  : (acc_q | ({24'b0, s_data} << {lane, 3'b000}));

  always_ff @(posedge clk) begin
    if (rst || swrst) begin
      st_q    <= ENG_IDLE;
      fcnt_q  <= '0;
      desc_q  <= '0;
      nxt_q   <= '0;
      buf_q   <= '0;
      blen_q  <= '0;
      boff_q  <= '0;
      acc_q   <= '0;
      sop_q   <= 1'b1;
      eop_q   <= 1'b0;
      inpkt_q <= 1'b0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      dnext_q <= '0;
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      case (st_q)
        ENG_IDLE: if (start) begin
          st_q   <= ENG_FETCH;
          desc_q <= head;
          fcnt_q <= '0;
        end
        ENG_FETCH: begin
          fcnt_q <= fcnt_q + 1'b1;
          if (fcnt_q < 3'd3) addr_q <= desc_w + MEM_AW'(fcnt_q);
          if (fcnt_q == 3'd2) nxt_q <= mem_rdata;
          if (fcnt_q == 3'd3) buf_q <= mem_rdata[MEM_AW+1:2];
          if (fcnt_q == 3'(FETCH_LAST)) begin
            blen_q <= mem_rdata[LEN_W-1:0];
            boff_q <= '0;
            st_q   <= ENG_DATA;
          end
        end
        ENG_DATA: if (take) begin
          acc_q  <= acc_n;
          boff_q <= boff_n;
          if (lane == 2'd3 || close_d) begin
            we_q    <= 1'b1;
            addr_q  <= buf_q + MEM_AW'(boff_q[LEN_W-1:2]);
            wdata_q <= acc_n;
          end
          if (close_d) begin
            eop_q <= s_last;
            st_q  <= ENG_WB;
          end
        end
        ENG_WB: begin
          we_q    <= 1'b1;
          addr_q  <= desc_w + MEM_AW'(3);
          wdata_q <= '0;
          wdata_q[ST_SOP] <= sop_q;
          wdata_q[ST_EOP] <= eop_q;
          wdata_q[ST_OWN] <= 1'b0;
          wdata_q[ST_EOQ] <= nxt_q == '0;
          wdata_q[LEN_W-1:0] <= boff_q;
          done_q  <= 1'b1;
          dnext_q <= nxt_q;
          sop_q   <= eop_q;
          inpkt_q <= !eop_q;
          st_q    <= ENG_IDLE;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
  assign done      = done_q;
  assign done_addr = desc_q;
  assign done_next = dnext_q;
  assign eng_idle  = st_q == ENG_IDLE && !inpkt_q && !done_q;

  assert_within_buffer_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ENG_DATA) |-> boff_q < blen_q);
  assert_owner_cleared_R3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (mem_we && !mem_wdata[ST_OWN]));
  assert_eoq_stops_R5: assert property (@(posedge clk) disable iff (rst || swrst)
    (done_q && dnext_q == '0) |=> st_q == ENG_IDLE);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    eng_idle |-> !mem_we);
  assert_reset_blocks_stream_R11: assert property (@(posedge clk) disable iff (rst)
    swrst |=> !s_ready);
endmodule

// File: rtl/desc_rx_dma.sv
module desc_rx_dma
  import dq_pkg::*;
#(
  parameter int MEM_AW     = 10,
  parameter int FREE_W     = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready
);
  logic              done, eng_idle, enable, idle_req, credit_nz, swrst;
  logic [DATA_W-1:0] done_addr, done_next, head;

  dq_regs #(.FREE_W(FREE_W), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .done(done), .done_addr(done_addr), .done_next(done_next),
    .eng_idle(eng_idle), .enable(enable), .idle_req(idle_req),
    .head(head), .credit_nz(credit_nz), .swrst(swrst)
  );

  dq_engine #(.MEM_AW(MEM_AW)) u_eng (
    .clk(clk), .rst(rst), .swrst(swrst), .enable(enable),
    .idle_req(idle_req), .head(head), .credit_nz(credit_nz),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready), .done(done),
    .done_addr(done_addr), .done_next(done_next), .eng_idle(eng_idle)
  );
endmodule

// File: tb/desc_rx_dma_test.sv
module desc_rx_dma_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [9:0]  mem_addr;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic        s_ready;

  logic [31:0] sram [0:1023];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_rx_dma uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready)
  );

  always @(posedge clk) begin
    if (mem_we) sram[mem_addr] <= mem_wdata;
    mem_rdata <= sram[mem_addr];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b, input logic l);
    s_valid = 1'b1; s_data = b; s_last = l;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_desc(input int a, input int nx, input int bf, input int ln);
    sram[a/4]     = nx;
    sram[a/4 + 1] = bf;
    sram[a/4 + 2] = ln;
    sram[a/4 + 3] = 32'h2000_0000;
  endtask

  function automatic logic [31:0] status_word(input bit sop, input bit eop,
                                              input bit eoq, input int cnt);
    return {sop, eop, 1'b0, eoq, 17'b0, cnt[10:0]};
  endfunction

  logic [31:0] v;
  int blen [NR];
  int ecnt [NR];
  logic [31:0] emode [NR];
  logic [7:0] ebyte [NR][32];
  logic [7:0] sb [512];
  bit sl [512];

  initial begin
    for (int i = 0; i < 1024; i++) sram[i] = '0;
    v = $urandom(32'd2024);
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, (a == 2) ? 32'h8000_0000 : 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 s_ready", {31'b0, s_ready}, 0);

    // R9: disabled, so nothing starts
    set_desc(32'h100, 0, 32'h400, 16);
    wr(6, 1);
    wr(4, 32'h100);
    idle(20);
    check("R9 no start when disabled", {31'b0, s_ready}, 0);
    // R6: head write while non-zero is ignored
    wr(4, 32'h200);
    rd(4, v);
    check("R6 head kept", v, 32'h100);
    // R2: enabling starts the channel
    wr(0, 1);
    idle(10);
    check("R2 ready after start", {31'b0, s_ready}, 1);
    for (int i = 0; i < 6; i++) push(8'h11 + 8'(i), i == 5);
    idle(6);
    check("R2 data word0", sram[256], 32'h1413_1211);
    check("R2 data word1", sram[257], 32'h0000_1615);
    check("R3 status single", sram[32'h100/4 + 3], status_word(1, 1, 1, 6));
    rd(4, v);
    check("R5 head zero", v, 0);
    check("R5 stopped", {31'b0, s_ready}, 0);
    rd(6, v);
    check("R8 credit used", v, 0);
    check("R7 irq pending", {31'b0, irq}, 1);
    wr(5, 32'h100);
    idle(2);
    check("R7 irq cleared", {31'b0, irq}, 0);

    // R8 zero credit, R4 spanning
    set_desc(32'h140, 32'h150, 32'h500, 8);
    set_desc(32'h150, 0, 32'h540, 8);
    wr(4, 32'h140);
    idle(20);
    check("R8 no start without credit", {31'b0, s_ready}, 0);
    wr(6, 2);
    for (int i = 0; i < 8; i++) push(8'h21 + 8'(i), 1'b0);
    idle(4);
    rd(4, v);
    check("R7 head follows next", v, 32'h150);
    for (int i = 8; i < 11; i++) push(8'h21 + 8'(i), i == 10);
    idle(6);
    check("R4 first status", sram[32'h140/4 + 3], status_word(1, 0, 0, 8));
    check("R4 second status", sram[32'h150/4 + 3], status_word(0, 1, 1, 3));
    check("R4 data a", sram[320], 32'h2423_2221);
    check("R4 data b", sram[321], 32'h2827_2625);
    check("R4 data c", sram[336], 32'h002B_2A29);
    wr(5, 32'h140);
    idle(3);
    check("R7 irq stays for older ack", {31'b0, irq}, 1);
    wr(5, 32'h150);
    idle(3);
    check("R7 irq clear on last ack", {31'b0, irq}, 0);

    // R10 idle request mid-packet
    set_desc(32'h180, 32'h190, 32'h600, 4);
    set_desc(32'h190, 0, 32'h640, 4);
    wr(6, 2);
    wr(4, 32'h180);
    push(8'h31, 0); push(8'h32, 0);
    wr(1, 32'h8);
    rd(2, v);
    check("R10 busy mid-packet", v, 0);
    for (int i = 2; i < 6; i++) push(8'h31 + 8'(i), i == 5);
    idle(6);
    check("R10 packet finished a", sram[32'h180/4 + 3], status_word(1, 0, 0, 4));
    check("R10 packet finished b", sram[32'h190/4 + 3], status_word(0, 1, 1, 2));
    check("R10 data", sram[400], 32'h0000_3635);
    rd(2, v);
    check("R10 idle flag", v, 32'h8000_0000);
    set_desc(32'h1C0, 0, 32'h680, 4);
    wr(6, 1);
    wr(4, 32'h1C0);
    idle(10);
    check("R10 parked", {31'b0, s_ready}, 0);
    wr(1, 0);
    idle(10);
    check("R10 resumed", {31'b0, s_ready}, 1);
    push(8'h41, 1);
    idle(6);
    check("R10 resumed status", sram[32'h1C0/4 + 3], status_word(1, 1, 1, 1));

    // R11 soft reset mid-packet
    set_desc(32'h1D0, 0, 32'h6C0, 8);
    wr(6, 1);
    wr(4, 32'h1D0);
    push(8'h51, 0); push(8'h52, 0);
    wr(3, 1);
    rd(3, v);
    check("R11 busy bit", v, 1);
    idle(10);
    rd(3, v);  check("R11 self clear", v, 0);
    rd(4, v);  check("R11 head", v, 0);
    rd(5, v);  check("R11 compl", v, 0);
    rd(6, v);  check("R11 credit", v, 0);
    check("R11 irq", {31'b0, irq}, 0);
    check("R11 ready", {31'b0, s_ready}, 0);
    set_desc(32'h1E0, 0, 32'h700, 8);
    wr(6, 1);
    wr(4, 32'h1E0);
    push(8'h61, 1);
    idle(6);
    check("R11 fresh packet", sram[32'h1E0/4 + 3], status_word(1, 1, 1, 1));
    wr(5, 32'h1E0);

    // Random chain: R2 R3 R4 R5 R8
    begin
      int d, o, tot, plen;
      bit first, lst;
      for (int i = 0; i < NR; i++) begin
        blen[i] = 1 + int'($urandom % 20);
        set_desc(32'h200 + 16*i, (i == NR-1) ? 0 : 32'h200 + 16*(i+1),
                 32'h800 + 32*i, blen[i]);
      end
      d = 0; o = 0; tot = 0; first = 1;
      while (d < NR) begin
        plen = 1 + int'($urandom % 30);
        for (int k = 0; k < plen; k++) begin
          lst = (k == plen-1) || (d == NR-1 && o+1 == blen[d]);
          sb[tot] = 8'($urandom);
          sl[tot] = lst;
          ebyte[d][o] = sb[tot];
          tot++;
          o++;
          if (o == blen[d] || lst) begin
            ecnt[d] = o;
            emode[d] = status_word(first, lst, d == NR-1, o);
            first = lst;
            d++;
            o = 0;
          end
          if (lst) break;
        end
      end
      wr(6, NR);
      wr(4, 32'h200);
      for (int t = 0; t < tot; t++) push(sb[t], sl[t]);
      idle(8);
      rd(4, v);  check("R5 random head", v, 0);
      rd(6, v);  check("R8 random credit", v, 0);
      for (int i = 0; i < NR; i++) begin
        logic [31:0] w;
        bit ok;
        check("R3 random status", sram[(32'h200 + 16*i)/4 + 3], emode[i]);
        ok = 1;
        for (int b = 0; b < ecnt[i]; b++) begin
          w = sram[(32'h800 + 32*i)/4 + b/4];
          if (w[8*(b%4) +: 8] !== ebyte[i][b]) ok = 0;
        end
        check("R2 random data", {31'b0, ok}, 1);
      end
      check("R7 random irq", {31'b0, irq}, 1);
      wr(5, 32'h200 + 16*(NR-1));
      idle(3);
      check("R7 random ack", {31'b0, irq}, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule